// File: doc/BRIEF.md
# Two-Stage Serial Clock Generator

This block derives the serial clock of a synchronous serial master from a faster module clock. The division is split into two cascaded stages. An even-only prescaler is followed by a rate divider that counts (rate + 1) prescaler ticks, so one full serial clock period lasts prescale × (1 + rate) module clocks. The serial clock toggles at each half period, which gives a 50 % duty cycle.

Software supplies the prescale and rate fields directly; the block does not work them out from a requested bit rate. While the enable is low, the block samples the divider fields and the polarity, clears both counters and parks the serial clock at its idle level. Once the enable is high, the sampled setting is frozen, so a change on the inputs cannot shorten or stretch a half period.

Next to the serial clock, the block issues two single-cycle strobes. One marks the edge on which the clock leaves its idle level and the other marks the edge on which it returns to it. A shift engine beside the block uses them to launch and capture data.

Top module: `sclk_gen_top`

## Requirements
- R1: While reset is asserted, `sclk`, `lead_stb` and `trail_stb` are all 0.
- R2: While `en` is low, `sclk` equals the `cpol` value sampled on the previous clock edge, and neither strobe is asserted. `cpol` = 0 means idle low and `cpol` = 1 means idle high.
- R3: With the setting frozen, every half period of `sclk` lasts (prescale / 2) × (rate + 1) module clocks, so a full period lasts prescale × (rate + 1) module clocks.
- R4: Bit 0 of `prescale` is ignored. An odd value behaves like the even value just below it.
- R5: A `prescale` of 0 (or 1) behaves like 2, so the smallest division always applies.
- R6: The minimum setting (prescale 2, rate 0) toggles `sclk` on every module clock, which is half the module clock rate.
- R7: `lead_stb` is high for exactly the one cycle in which `sclk` moves away from its idle level. `trail_stb` is high for exactly the one cycle in which `sclk` returns to idle. The two strobes are never high together, and `sclk` never changes while enabled without one of them.
- R8: `prescale`, `rate` and `cpol` are sampled only while `en` is low. Changes made while `en` is high have no effect on the period or on the idle level until the next disabled cycle.
- R9: After `en` rises, the first leading edge of `sclk` comes one full half period later, counted from the first enabled clock edge.
- R10: The maximum setting (prescale 254, rate 255) yields a half period of 32512 module clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low parks the clock and samples the setting |
| prescale | input | PRE_W | Even prescale value; bit 0 ignored, 0 treated as 2 |
| rate | input | RATE_W | Rate divider value; divides by rate + 1 |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Generated serial clock |
| lead_stb | output | 1 | One-cycle strobe on the edge leaving idle |
| trail_stb | output | 1 | One-cycle strobe on the edge returning to idle |

## Verification
The assertions check several properties on every clock:
- the idle level and quiet strobes while disabled;
- strobe exclusivity and the direction of each strobe;
- the rule that `sclk` never moves without a strobe;
- the frozen setting while enabled;
- the exact length of every half period, measured by a free-running gap counter against the product of the two frozen fields.

Only the bench scenarios show that the sampled setting is the one software intended. This covers the odd and zero prescale substitutions, the first leading edge after enable, and input changes made mid-run being ignored.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

    localparam int unsigned PRE_W_DEFAULT  = 8;
    localparam int unsigned RATE_W_DEFAULT = 8;

    // Which transition, if any, the rate stage makes on a given edge.
    typedef enum logic [1:0] {
        EDGE_NONE  = 2'b00,
        EDGE_LEAD  = 2'b01,
        EDGE_TRAIL = 2'b10
    } edge_kind_e;

    // Effective half prescale: bit 0 dropped, zero promoted to one.
    function automatic int unsigned half_of(input int unsigned pre);
        int unsigned h;
        h = pre >> 1;
        return (h == 0) ? 1 : h;
    endfunction

endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold #(
    parameter int unsigned PRE_W  = 8,
    parameter int unsigned RATE_W = 8,
    localparam int unsigned HALF_W = PRE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PRE_W-1:0]  prescale,
    input  logic [RATE_W-1:0] rate,
    input  logic              cpol,
    output logic [HALF_W-1:0] half_pre,
    output logic [RATE_W-1:0] rate_q,
    output logic              cpol_q
);

    typedef struct packed {
        logic [HALF_W-1:0] half;
        logic [RATE_W-1:0] rate;
        logic              cpol;
    } cfg_t;

    cfg_t st_d, st_q;
    logic [HALF_W-1:0] half_raw;

    assign half_raw = prescale[PRE_W-1:1];

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.half = (half_raw == '0) ? HALF_W'(1) : half_raw;
            st_d.rate = rate;
            st_d.cpol = cpol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{half: HALF_W'(1), rate: '0, cpol: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign half_pre = st_q.half;
    assign rate_q   = st_q.rate;
    assign cpol_q   = st_q.cpol;

    // R8: the held setting cannot move across an enabled edge
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en) |-> $stable(st_q));

    // R5: the effective half prescale is never zero
    p_half_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.half != '0);

endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
    parameter int unsigned HALF_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half_pre,
    output logic              tick
);

    typedef struct packed {
        logic [HALF_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic    wrap;

    assign wrap = (st_q.cnt == half_pre - HALF_W'(1));

    always_comb begin
        st_d = st_q;
        if (!run || wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + HALF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = run && wrap;

    // R3: the prescale counter stays inside its window
    p_pre_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (st_q.cnt < half_pre));

endmodule

// File: rtl/sclk_rate_stage.sv
module sclk_rate_stage
    import sclk_gen_pkg::*;
#(
    parameter int unsigned RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    input  logic              idle_lvl_next,
    input  logic              idle_lvl,
    output logic              sclk,
    output logic              lead_stb,
    output logic              trail_stb
);

    typedef struct packed {
        logic [RATE_W-1:0] cnt;
        logic              sclk;
        edge_kind_e        kind;
    } rate_st_t;

    rate_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.kind = EDGE_NONE;
        if (!run) begin
            st_d.cnt  = '0;
            st_d.sclk = idle_lvl_next;
        end else if (tick) begin
            if (st_q.cnt == rate) begin
                st_d.cnt  = '0;
                st_d.sclk = ~st_q.sclk;
                st_d.kind = (st_q.sclk == idle_lvl) ? EDGE_LEAD : EDGE_TRAIL;
            end else begin
                st_d.cnt = st_q.cnt + RATE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, sclk: 1'b0, kind: EDGE_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk      = st_q.sclk;
    assign lead_stb  = (st_q.kind == EDGE_LEAD);
    assign trail_stb = (st_q.kind == EDGE_TRAIL);

    // R3: the rate counter never passes the frozen rate value
    p_rate_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (st_q.cnt <= rate));

endmodule

// File: rtl/sclk_gen_top.sv
module sclk_gen_top
    import sclk_gen_pkg::*;
#(
    parameter int unsigned PRE_W  = PRE_W_DEFAULT,
    parameter int unsigned RATE_W = RATE_W_DEFAULT,
    localparam int unsigned HALF_W = PRE_W - 1,
    localparam int unsigned GAP_W  = PRE_W + RATE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PRE_W-1:0]  prescale,
    input  logic [RATE_W-1:0] rate,
    input  logic              cpol,
    output logic              sclk,
    output logic              lead_stb,
    output logic              trail_stb
);

    logic [HALF_W-1:0] half_pre;
    logic [RATE_W-1:0] rate_q;
    logic              cpol_q;
    logic              tick;

    sclk_cfg_hold #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .prescale (prescale),
        .rate     (rate),
        .cpol     (cpol),
        .half_pre (half_pre),
        .rate_q   (rate_q),
        .cpol_q   (cpol_q)
    );

    sclk_prescaler #(.HALF_W(HALF_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (en),
        .half_pre (half_pre),
        .tick     (tick)
    );

    sclk_rate_stage #(.RATE_W(RATE_W)) u_rate (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (en),
        .tick          (tick),
        .rate          (rate_q),
        .idle_lvl_next (cpol),
        .idle_lvl      (cpol_q),
        .sclk          (sclk),
        .lead_stb      (lead_stb),
        .trail_stb     (trail_stb)
    );

    // Independent half-period measurement for the checks below.
    logic [GAP_W-1:0] gap_d, gap_q;
    logic [GAP_W-1:0] exp_half;

    assign exp_half = GAP_W'(half_pre) * (GAP_W'(rate_q) + GAP_W'(1));

    always_comb begin
        if (!en) begin
            gap_d = '0;
        end else if (lead_stb || trail_stb) begin
            gap_d = GAP_W'(1);
        end else begin
            gap_d = gap_q + GAP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_d;
        end
    end

    // R3, R9: each strobe lands exactly one half period after the last
    p_half_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_stb || trail_stb) |-> (gap_q == exp_half));

    // R2: disabled means idle level and quiet strobes
    p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (sclk == $past(cpol)) && !lead_stb && !trail_stb);

    // R7: strobes are exclusive
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_stb && trail_stb));

    // R7: leading strobe means sclk just left idle
    p_lead_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |-> (sclk != cpol_q) && (sclk != $past(sclk)));

    // R7: trailing strobe means sclk just returned to idle
    p_trail_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |-> (sclk == cpol_q) && (sclk != $past(sclk)));

    // R7: while running, sclk never moves without a strobe
    p_no_silent_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && (sclk != $past(sclk))) |-> (lead_stb || trail_stb));

endmodule

// File: tb/tb_sclk_gen_top.sv
`timescale 1ns/1ps
module tb_sclk_gen_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] prescale = 8'd2;
    logic [7:0] rate = 8'd0;
    logic       cpol = 1'b0;
    logic       sclk, lead_stb, trail_stb;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    sclk_gen_top dut (
        .clk(clk), .rst_n(rst_n), .en(en), .prescale(prescale),
        .rate(rate), .cpol(cpol), .sclk(sclk),
        .lead_stb(lead_stb), .trail_stb(trail_stb)
    );

    typedef struct packed {
        logic [7:0]  pre;
        logic [7:0]  rt;
        logic        pol;
        logic [31:0] half;
        logic [31:0] tag;
    } vec_t;

    // half = max(pre/2,1) * (rt+1), computed by hand from R3-R6
    localparam vec_t VECS [0:6] = '{
        '{8'd2,  8'd0,   1'b0, 32'd1,   32'd6},  // R6 minimum
        '{8'd4,  8'd0,   1'b1, 32'd2,   32'd3},
        '{8'd6,  8'd3,   1'b0, 32'd12,  32'd3},
        '{8'd5,  8'd2,   1'b0, 32'd6,   32'd4},  // R4 odd prescale
        '{8'd0,  8'd4,   1'b1, 32'd5,   32'd5},  // R5 zero prescale
        '{8'd10, 8'd1,   1'b1, 32'd10,  32'd3},
        '{8'd2,  8'd255, 1'b0, 32'd256, 32'd3}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_strobe(output int n, output logic ld, output logic tr);
        n = 0; ld = 1'b0; tr = 1'b0;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk);
            n++;
            if (lead_stb || trail_stb) begin
                ld = lead_stb; tr = trail_stb;
                return;
            end
        end
        n_checks++; n_fail++;
        $display("FAIL R7 no strobe seen actual=%0d expected=<70000", n);
    endtask

    task automatic setup(input logic [7:0] p, input logic [7:0] r, input logic c);
        @(negedge clk);
        en = 1'b0; prescale = p; rate = r; cpol = c;
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int n;
        logic ld, tr;
        bit quiet;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(sclk == 1'b0, "R1 sclk in reset", sclk, 0);
        check(!lead_stb && !trail_stb, "R1 strobes in reset", lead_stb + trail_stb, 0);
        rst_n = 1'b1;

        // R2: disabled with idle-high polarity
        cpol = 1'b1;
        quiet = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (lead_stb || trail_stb) quiet = 1'b0;
        end
        check(sclk == 1'b1, "R2 idle high", sclk, 1);
        check(quiet, "R2 no strobe while disabled", quiet, 1);
        @(negedge clk); cpol = 1'b0;
        @(negedge clk);
        check(sclk == 1'b0, "R2 idle low", sclk, 0);

        // Table walk: R3, R4, R5, R6, R7, R9
        foreach (VECS[k]) begin
            setup(VECS[k].pre, VECS[k].rt, VECS[k].pol);
            wait_strobe(n, ld, tr);
            check(n == int'(VECS[k].half), "R9 first lead delay", n, int'(VECS[k].half));
            check(ld && !tr && sclk != VECS[k].pol, "R7 leading strobe", sclk, !VECS[k].pol);
            wait_strobe(n, ld, tr);
            check(n == int'(VECS[k].half), "R3 half period", n, int'(VECS[k].half));
            check(tr && !ld && sclk == VECS[k].pol, "R7 trailing strobe", sclk, VECS[k].pol);
        end

        // R6: minimum setting toggles sclk every cycle
        setup(8'd2, 8'd0, 1'b0);
        begin
            logic prev;
            bit every;
            every = 1'b1;
            @(negedge clk); prev = sclk;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (sclk == prev) every = 1'b0;
                prev = sclk;
            end
            check(every, "R6 toggle each clock", every, 1);
        end

        // R8: input changes while enabled are ignored
        setup(8'd4, 8'd1, 1'b0);
        wait_strobe(n, ld, tr);
        check(n == 4 && ld, "R8 baseline lead", n, 4);
        prescale = 8'd20; rate = 8'd9; cpol = 1'b1;
        wait_strobe(n, ld, tr);
        check(n == 4 && tr, "R8 period unchanged", n, 4);
        check(sclk == 1'b0, "R8 idle level unchanged", sclk, 0);
        wait_strobe(n, ld, tr);
        check(n == 4 && ld, "R8 next lead unchanged", n, 4);

        // R10: maximum setting
        setup(8'd254, 8'd255, 1'b1);
        wait_strobe(n, ld, tr);
        check(n == 32512, "R10 max half period", n, 32512);
        check(ld && sclk == 1'b0, "R10 lead at max", sclk, 0);

        @(negedge clk); en = 1'b0;
        finish_run();
    end

endmodule